// File: doc/BRIEF.md
# Flash Read-Side Mode Multiplexer

This block is the read datapath of a parallel NOR flash model with a command-driven front end. A separate write sequencer decides which command mode the device is in. For each bus read, this block picks the word to return from one of four sources. In plain read mode it returns the array bytes. In autoselect mode it returns identification words. While a program or erase operation runs, it returns a status byte whose bit 6 flips on every poll. In query mode it returns bytes from a parameter table.

The array storage sits outside the block. It supplies four consecutive bytes starting at the read address, with the lowest address in byte 0. The device bus width, sector size and sector count are parameters. The query table is built from the sector size and sector count at elaboration time. A read is requested by a one-cycle strobe. The selected word is registered and appears one clock later, together with a valid flag. A mode code the block does not know is served as an array read, and the block raises an error pulse so the sequencer can return to read mode.

Top module: `flash_rd_mux`

## Requirements
- R1: The table offset is the low 8 address bits shifted right by 0, 1 or 2 for a device width of 1, 2 or 4 bytes (parameter DEV_BYTES).
- R2: In mode 0 (read) and mode 1 (second unlock of an erase sequence), the result is `arr_data` in little-endian order, masked by `rd_size`: 0 keeps byte 0, 1 keeps bytes 0–1, and 2 or 3 keeps all four bytes. Unkept bytes read as zero.
- R3: In mode 2 (autoselect), offset 0 returns `id_manuf`, offset 1 returns `id_device`, and offset 2 returns zero. Each value is zero-extended to 32 bits.
- R4: In mode 2, offset 0x0E returns `id_ext0` and offset 0x0F returns `id_ext1`. If the selected word is 0xFFFF, or the offset is any other value, the result is array data as in R2.
- R5: In modes 3 (program), 4 (chip erase) and 5 (sector erase), the result is the status byte, zero-extended. Each such read inverts status bit 6 at the same clock edge, after the old value has been captured.
- R6: `status_load` writes `status_in` into the status byte. It wins over a toggle requested in the same cycle. Reset clears the status byte to zero.
- R7: In mode 6 (query), the result is the table byte at the offset, zero-extended. The table holds:
  - "QRY" at 0x10–0x12.
  - 0x02, 0x00 at 0x13–0x14.
  - log2 of the total byte count at 0x27.
  - 0x01 at 0x2C.
  - Sector count minus one, low byte first, at 0x2D–0x2E.
  - Sector size divided by 256, low byte first, at 0x2F–0x30.
  - Timing and voltage bytes at 0x1B–0x26 and 0x28.
  - Zero at every other offset.
- R8: In mode 6, every offset of 0x52 or above returns zero.
- R9: Mode 7 is invalid. A read in mode 7 returns array data as in R2 and raises `mode_err` for exactly the cycle in which its data is valid.
- R10: `rd_data`, `rd_valid` and `mode_err` are registered one cycle after `rd_en`. `rd_data` holds its value when no read occurs. A synchronous reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one read per cycle |
| rd_addr_lo | input | 8 | Low byte of the read byte address |
| rd_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| mode | input | 3 | Command mode from the sequencer (codes in R2–R9) |
| arr_data | input | 32 | Four array bytes from the read address upward |
| id_manuf | input | 16 | Manufacturer identification word |
| id_device | input | 16 | Device identification word |
| id_ext0 | input | 16 | First extended identification word |
| id_ext1 | input | 16 | Second extended identification word |
| status_load | input | 1 | Write strobe for the status byte |
| status_in | input | 8 | Status value to load |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | High the cycle after a read strobe |
| mode_err | output | 1 | Invalid mode seen on the read now returning |

## Verification
The bench keeps a behavioural model and compares it against the outputs on every clock. Array reads use all four size codes at several addresses, so that a wrong mask or byte order changes a specific byte. Autoselect reads cover the identification offsets and neighbouring offsets, with the extended words set both to real values and to all ones; this separates a real hit from the array fallback. Status reads are repeated back to back in each busy mode, including a load in the same cycle as a read, which exposes a missed or doubled toggle and the load priority. Query reads sweep the table, then the offsets at and beyond its end, and the invalid mode code is mixed between them.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [2:0] {
    MD_READ    = 3'd0,
    MD_UNLOCK2 = 3'd1,
    MD_AUTOSEL = 3'd2,
    MD_PROG    = 3'd3,
    MD_CHIPERS = 3'd4,
    MD_SECTERS = 3'd5,
    MD_QUERY   = 3'd6,
    MD_BAD     = 3'd7
  } rd_mode_e;

  localparam logic [7:0] QRY_LEN = 8'h52;
  localparam logic [7:0] TOGGLE_MASK = 8'h40;

  function automatic logic is_busy_mode(input logic [2:0] m);
    return (m == MD_PROG) || (m == MD_CHIPERS) || (m == MD_SECTERS);
  endfunction

endpackage

// File: rtl/rdm_array_lane.sv
module rdm_array_lane #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] arr,
  input  logic [1:0]         size,
  output logic [8*LANES-1:0] word
);
  logic [2:0] nbytes;

  always_comb begin
    case (size)
      2'd0:    nbytes = 3'd1;
      2'd1:    nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word[8*g +: 8] = (3'(g) < nbytes) ? arr[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/rdm_id_lookup.sv
module rdm_id_lookup (
  input  logic [7:0]  ofs,
  input  logic [15:0] manuf,
  input  logic [15:0] device,
  input  logic [15:0] ext0,
  input  logic [15:0] ext1,
  output logic        hit,
  output logic [15:0] val
);
  always_comb begin
    hit = 1'b1;
    val = 16'h0000;
    case (ofs)
      8'h00: val = manuf;
      8'h01: val = device;
      8'h02: val = 16'h0000;
      8'h0E: begin
        val = ext0;
        hit = (ext0 != 16'hFFFF);
      end
      8'h0F: begin
        val = ext1;
        hit = (ext1 != 16'hFFFF);
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rdm_query_table.sv
module rdm_query_table #(
  parameter int SECTOR_BYTES = 65536,
  parameter int SECTOR_COUNT = 16
) (
  input  logic [7:0] ofs,
  output logic [7:0] entry
);
  import flash_rd_pkg::*;

  localparam int TOTAL_BYTES = SECTOR_BYTES * SECTOR_COUNT;
  localparam int SIZE_LOG2   = $clog2(TOTAL_BYTES);
  localparam logic [31:0] CNT_M1 = 32'(SECTOR_COUNT - 1);
  localparam logic [31:0] SZ_256 = 32'(SECTOR_BYTES / 256);

  always_comb begin
    entry = 8'h00;
    if (ofs < QRY_LEN) begin
      case (ofs)
        8'h10: entry = 8'h51;
        8'h11: entry = 8'h52;
        8'h12: entry = 8'h59;
        8'h13: entry = 8'h02;
        8'h1B: entry = 8'h27;
        8'h1C: entry = 8'h36;
        8'h1F: entry = 8'h07;
        8'h20: entry = 8'h04;
        8'h21: entry = 8'h09;
        8'h22: entry = 8'h0C;
        8'h23: entry = 8'h01;
        8'h24: entry = 8'h04;
        8'h25: entry = 8'h0A;
        8'h26: entry = 8'h0D;
        8'h27: entry = 8'(SIZE_LOG2);
        8'h28: entry = 8'h02;
        8'h2C: entry = 8'h01;
        8'h2D: entry = CNT_M1[7:0];
        8'h2E: entry = CNT_M1[15:8];
        8'h2F: entry = SZ_256[7:0];
        8'h30: entry = SZ_256[15:8];
        default: entry = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rdm_status_reg.sv
module rdm_status_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       toggle,
  output logic [7:0] status_q
);
  import flash_rd_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)         status_q <= 8'h00;
    else if (load)   status_q <= load_val;
    else if (toggle) status_q <= status_q ^ TOGGLE_MASK;
  end
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux #(
  parameter int DEV_BYTES    = 2,
  parameter int SECTOR_BYTES = 65536,
  parameter int SECTOR_COUNT = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_en,
  input  logic [7:0]  rd_addr_lo,
  input  logic [1:0]  rd_size,
  input  logic [2:0]  mode,
  input  logic [31:0] arr_data,
  input  logic [15:0] id_manuf,
  input  logic [15:0] id_device,
  input  logic [15:0] id_ext0,
  input  logic [15:0] id_ext1,
  input  logic        status_load,
  input  logic [7:0]  status_in,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        mode_err
);
  import flash_rd_pkg::*;

  localparam int OFS_SHIFT = (DEV_BYTES >= 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;

  logic [7:0]  ofs;
  logic [31:0] arr_word;
  logic        id_hit;
  logic [15:0] id_val;
  logic [7:0]  qry_byte;
  logic [7:0]  stat_q;
  logic        stat_rd;
  logic [31:0] sel_data;

  assign ofs     = rd_addr_lo >> OFS_SHIFT;
  assign stat_rd = rd_en && is_busy_mode(mode);

  rdm_array_lane #(.LANES(4)) u_lane (
    .arr(arr_data), .size(rd_size), .word(arr_word)
  );

  rdm_id_lookup u_id (
    .ofs(ofs), .manuf(id_manuf), .device(id_device),
    .ext0(id_ext0), .ext1(id_ext1), .hit(id_hit), .val(id_val)
  );

  rdm_query_table #(.SECTOR_BYTES(SECTOR_BYTES), .SECTOR_COUNT(SECTOR_COUNT)) u_qry (
    .ofs(ofs), .entry(qry_byte)
  );

  rdm_status_reg u_stat (
    .clk(clk), .rst(rst), .load(status_load), .load_val(status_in),
    .toggle(stat_rd), .status_q(stat_q)
  );

  always_comb begin
    case (mode)
      MD_AUTOSEL: sel_data = id_hit ? {16'h0000, id_val} : arr_word;
      MD_PROG, MD_CHIPERS, MD_SECTERS: sel_data = {24'h0, stat_q};
      MD_QUERY: sel_data = {24'h0, qry_byte};
      default: sel_data = arr_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= 32'h0;
      rd_valid <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      mode_err <= rd_en && (mode == MD_BAD);
      if (rd_en) rd_data <= sel_data;
    end
  end
endmodule

// File: rtl/flash_rd_mux_chk.sv
module flash_rd_mux_chk #(
  parameter int DEV_BYTES = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        rd_en,
  input logic [7:0]  rd_addr_lo,
  input logic [2:0]  mode,
  input logic        status_load,
  input logic [7:0]  status_in,
  input logic [7:0]  stat_q,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        mode_err
);
  localparam int SH = (DEV_BYTES >= 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;
  logic [7:0] chk_ofs;
  assign chk_ofs = rd_addr_lo >> SH;

  // R5
  busy_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (mode >= 3'd3) && (mode <= 3'd5) && !status_load)
      |=> (stat_q[6] != $past(stat_q[6])));

  // R6
  status_load_chk: assert property (@(posedge clk) disable iff (rst)
    status_load |=> (stat_q == $past(status_in)));

  // R8
  query_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (mode == 3'd6) && (chk_ofs >= 8'h52)) |=> (rd_data == 32'h0));

  // R9
  bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (mode == 3'd7)) |=> (mode_err && rd_valid));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(rd_data) && !rd_valid && !mode_err));
endmodule

bind flash_rd_mux flash_rd_mux_chk #(.DEV_BYTES(DEV_BYTES)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr_lo(rd_addr_lo), .mode(mode),
  .status_load(status_load), .status_in(status_in), .stat_q(stat_q),
  .rd_data(rd_data), .rd_valid(rd_valid), .mode_err(mode_err)
);

// File: tb/sim_flash_rd_mux.sv
`timescale 1ns/1ps
module sim_flash_rd_mux;
  localparam int DEVB = 2;
  localparam int SECB = 65536;
  localparam int SECN = 16;

  logic clk = 0, rst = 1, rd_en = 0, status_load = 0;
  logic [7:0] rd_addr_lo = 0, status_in = 0;
  logic [1:0] rd_size = 0;
  logic [2:0] mode = 0;
  logic [31:0] arr_data;
  logic [15:0] id_manuf = 16'h0001, id_device = 16'h227E;
  logic [15:0] id_ext0 = 16'h2210, id_ext1 = 16'hFFFF;
  logic [31:0] rd_data;
  logic rd_valid, mode_err;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R10";

  logic [31:0] e_data = 0;
  logic e_valid = 0, e_err = 0;
  logic [7:0] m_stat = 0;

  always #4 clk = ~clk;

  assign arr_data = {rd_addr_lo + 8'd3, rd_addr_lo + 8'd2, rd_addr_lo + 8'd1, rd_addr_lo} ^ 32'h5AC3_3C96;

  flash_rd_mux #(.DEV_BYTES(DEVB), .SECTOR_BYTES(SECB), .SECTOR_COUNT(SECN)) u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr_lo(rd_addr_lo), .rd_size(rd_size),
    .mode(mode), .arr_data(arr_data), .id_manuf(id_manuf), .id_device(id_device),
    .id_ext0(id_ext0), .id_ext1(id_ext1), .status_load(status_load),
    .status_in(status_in), .rd_data(rd_data), .rd_valid(rd_valid), .mode_err(mode_err)
  );

  function automatic int log2i(input longint v);
    int n = 0;
    while ((longint'(1) << n) < v) n++;
    return n;
  endfunction

  function automatic logic [7:0] qry_ref(input int o);
    int cnt = SECN - 1;
    int sz = SECB / 256;
    if (o >= 'h52) return 8'h00;
    if (o == 'h10) return "Q";
    if (o == 'h11) return "R";
    if (o == 'h12) return "Y";
    if (o == 'h13) return 8'h02;
    if (o == 'h27) return 8'(log2i(longint'(SECB) * SECN));
    if (o == 'h2C) return 8'h01;
    if (o == 'h2D) return 8'(cnt % 256);
    if (o == 'h2E) return 8'(cnt / 256);
    if (o == 'h2F) return 8'(sz % 256);
    if (o == 'h30) return 8'(sz / 256);
    case (o)
      'h1B: return 8'h27;  'h1C: return 8'h36;  'h1F: return 8'h07;
      'h20: return 8'h04;  'h21: return 8'h09;  'h22: return 8'h0C;
      'h23: return 8'h01;  'h24: return 8'h04;  'h25: return 8'h0A;
      'h26: return 8'h0D;  'h28: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] arr_ref();
    int keep = (rd_size == 0) ? 1 : (rd_size == 1) ? 2 : 4;
    logic [31:0] r = 0;
    for (int i = 0; i < keep; i++) r[8*i +: 8] = arr_data[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] read_ref(input logic [7:0] st);
    int o = int'(rd_addr_lo) / DEVB;
    case (mode)
      3'd2: begin
        if (o == 0) return {16'h0, id_manuf};
        if (o == 1) return {16'h0, id_device};
        if (o == 2) return 32'h0;
        if (o == 14 && id_ext0 != 16'hFFFF) return {16'h0, id_ext0};
        if (o == 15 && id_ext1 != 16'hFFFF) return {16'h0, id_ext1};
        return arr_ref();
      end
      3'd3, 3'd4, 3'd5: return {24'h0, st};
      3'd6: return {24'h0, qry_ref(o)};
      default: return arr_ref();
    endcase
  endfunction

  // reference model, advanced on each edge
  always @(posedge clk) begin
    if (rst) begin
      e_data = 0; e_valid = 0; e_err = 0; m_stat = 0;
    end else begin
      e_valid = rd_en;
      e_err = rd_en && (mode == 3'd7);
      if (rd_en) e_data = read_ref(m_stat);
      if (status_load) m_stat = status_in;
      else if (rd_en && mode >= 3 && mode <= 5) m_stat = m_stat ^ 8'h40;
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rd_data !== e_data || rd_valid !== e_valid || mode_err !== e_err) begin
        errors++;
        $display("FAIL %s: data=%h valid=%b err=%b expected data=%h valid=%b err=%b",
                 tag, rd_data, rd_valid, mode_err, e_data, e_valid, e_err);
      end
    end
  end

  task automatic rd(input string t, input logic [2:0] m, input logic [7:0] a, input logic [1:0] s);
    @(negedge clk);
    tag = t; mode = m; rd_addr_lo = a; rd_size = s; rd_en = 1;
    @(posedge clk);
    #1 rd_en = 0;
  endtask

  task automatic idle(input string t, input int n);
    tag = t;
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    tag = "R10";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    idle("R10", 2);
    // R2 sizes and addresses in read and unlock modes
    for (int s = 0; s < 4; s++) rd("R2", 3'd0, 8'(8'h11 + 8'(s * 40)), 2'(s));
    rd("R2", 3'd1, 8'hA4, 2'd2);
    rd("R2", 3'd1, 8'h07, 2'd1);
    // R1 offset shift seen through autoselect: addr 2 -> offset 1
    rd("R1", 3'd2, 8'h02, 2'd1);
    rd("R1", 3'd2, 8'h03, 2'd1);
    // R3
    rd("R3", 3'd2, 8'h00, 2'd1);
    rd("R3", 3'd2, 8'h04, 2'd1);
    // R4
    rd("R4", 3'd2, 8'h1C, 2'd1);
    rd("R4", 3'd2, 8'h1E, 2'd2);
    rd("R4", 3'd2, 8'h0A, 2'd2);
    @(negedge clk); id_ext0 = 16'hFFFF; id_ext1 = 16'h0C01;
    rd("R4", 3'd2, 8'h1C, 2'd2);
    rd("R4", 3'd2, 8'h1E, 2'd2);
    // R5 / R6 status polling
    @(negedge clk); tag = "R6"; status_load = 1; status_in = 8'h80;
    @(posedge clk); #1 status_load = 0;
    for (int k = 0; k < 3; k++) rd("R5", 3'd3, 8'h00, 2'd0);
    rd("R5", 3'd4, 8'h40, 2'd2);
    rd("R5", 3'd5, 8'h80, 2'd1);
    rd("R5", 3'd5, 8'h80, 2'd1);
    @(negedge clk); tag = "R6"; status_load = 1; status_in = 8'h3C;
    mode = 3'd4; rd_en = 1;
    @(posedge clk); #1 status_load = 0; rd_en = 0;
    rd("R6", 3'd4, 8'h00, 2'd0);
    rd("R6", 3'd4, 8'h00, 2'd0);
    // R7 table sweep
    for (int o = 'h0E; o <= 'h32; o++) rd("R7", 3'd6, 8'(o * 2), 2'd0);
    // R8 tail
    rd("R8", 3'd6, 8'hA2, 2'd0);
    rd("R8", 3'd6, 8'hA4, 2'd0);
    rd("R8", 3'd6, 8'hFE, 2'd2);
    // R9
    rd("R9", 3'd7, 8'h33, 2'd2);
    rd("R9", 3'd6, 8'h20, 2'd0);
    rd("R9", 3'd7, 8'h90, 2'd0);
    // R10 hold and reset
    idle("R10", 3);
    @(negedge clk); rst = 1; tag = "R10";
    @(posedge clk); #1 rst = 0;
    idle("R10", 2);
    rd("R10", 3'd0, 8'h55, 2'd2);
    idle("R10", 2);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R10: watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule